// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a control transfer on the device side of endpoint zero. Each cycle it may receive one decoded token event: a SETUP with its 8-byte request payload, an OUT with the byte count and toggle bit of the data packet the host sent, or an IN that stands for a data packet the device delivered and the host acknowledged. From these events it moves through the setup, optional data and status stages. It reports the current stage, the data toggle expected on the next data packet, and the number of bytes the device must place in its next IN packet.

The request direction and the requested length come from the setup payload. The block counts the remaining bytes against that length and the maximum packet size. Any sequence the protocol does not allow moves it to a halted stage and raises a stall flag. Only the next SETUP clears that flag. A SETUP is always accepted, even in the middle of a transfer, and it restarts the sequence. A one-cycle completion pulse marks the end of a successful status stage. Request decoding, descriptor storage and the line interface sit outside the block.

Top module: `ep0_ctl_seq`

## Requirements
- R1: After a synchronous active-low reset the stage is idle (code 0), the stall flag is 0, the expected toggle is 0 (DATA0), the transmit length is 0 and the completion pulse is 0.
- R2: A SETUP event (token code 3) is accepted in every stage, including the halted one. On the next cycle the stall flag is 0 and the expected toggle is 1 (DATA1). A SETUP that arrives in the middle of a transfer abandons it.
- R3: A SETUP whose requested length is zero moves the block to status-IN (stage code 3) with an expected toggle of DATA1.
- R4: The direction is bit 7 of setup byte 0 (payload bit 7; 1 means device to host). The requested length is bytes 6 and 7, little-endian (payload bits 63:48). A nonzero length moves the block to data-IN (code 2) when the direction is device to host, and to data-OUT (code 1) otherwise.
- R5: In data-OUT, an OUT packet (token code 1) whose toggle equals the expected toggle is accepted and flips the toggle. A packet with the other toggle is a repeat: it is discarded and changes neither the stage, the toggle nor the count.
- R6: An accepted OUT data packet that is shorter than the maximum packet size, or that uses up the remaining length, ends the data stage: the block moves to status-IN with the toggle set to DATA1.
- R7: An OUT data packet longer than the remaining length or longer than the maximum packet size moves the block to halted (code 5) with the stall flag set.
- R8: In data-IN the transmit length equals the smaller of the remaining length and the maximum packet size. Each IN event (token code 2) uses up that many bytes and flips the toggle. A short packet, or one that uses up the remaining length, moves the block to status-OUT (code 4) with DATA1. Outside data-IN the transmit length is 0.
- R9: The status stage completes on an IN in status-IN, or on a zero-length DATA1 OUT in status-OUT. The block returns to idle and raises the completion pulse for exactly one cycle.
- R10: A zero-length DATA1 OUT during data-IN is an early status stage: the block returns to idle with a completion pulse.
- R11: An IN or OUT in idle, an IN in data-OUT, an OUT in status-IN, an IN in status-OUT, or an OUT in status-OUT other than a zero-length DATA1 packet moves the block to halted with the stall flag set. While halted, IN and OUT events are ignored and the stall flag stays set.
- R12: A cycle with the valid flag low, or with token code 0, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | A token event is present this cycle |
| tok_kind | input | 2 | Token code: 0 none, 1 OUT, 2 IN, 3 SETUP |
| setup_bytes | input | 64 | Setup payload, byte n on bits 8n+7:8n |
| rx_len | input | LEN_W | Byte count of the OUT data packet |
| rx_pid | input | 1 | Toggle of the OUT data packet (0 DATA0, 1 DATA1) |
| stage | output | 3 | Current stage code (0 idle, 1 data-OUT, 2 data-IN, 3 status-IN, 4 status-OUT, 5 halted) |
| exp_pid | output | 1 | Toggle expected on the next data packet |
| stall | output | 1 | Protocol stall in force |
| tx_len | output | LEN_W | Bytes the device must send in its next IN packet |
| xfer_done | output | 1 | One-cycle pulse when a status stage completes |

## Verification
Every output is registered, so the results of an event on one clock edge are due one cycle later. The stage, stall flag, toggle, transmit length and completion pulse all appear together after that single edge. The bench drives each event on a falling edge and samples all outputs on the next falling edge. Each result is therefore read exactly one rising edge after its stimulus, and a completion pulse is seen in its only cycle and then seen to drop. Repeat packets, ignored tokens and events in the halted stage are checked by reading all outputs in the cycle after the event, before the next event is driven.

// File: rtl/ep0_ctl_pkg.sv
// Package: shared types for the endpoint-zero control sequencer.
// Assumes: token and stage codes are fixed; neighbours decode them.
package ep0_ctl_pkg;

    localparam int REQ_W = 16;  // width of the requested length field

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_SETUP = 2'd3
    } tok_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DOUT = 3'd1,
        ST_DIN  = 3'd2,
        ST_SIN  = 3'd3,
        ST_SOUT = 3'd4,
        ST_HALT = 3'd5
    } stage_e;

    typedef struct packed {
        logic             to_host;
        logic [REQ_W-1:0] req_len;
    } setup_info_t;

endpackage

// File: rtl/ep0_setup_decode.sv
// Module: pulls direction and requested length out of the 8-byte setup
// payload. Purely combinational.
// Assumes: byte n of the payload sits on bits 8n+7:8n.
module ep0_setup_decode
    import ep0_ctl_pkg::*;
(
    input  logic [63:0]  setup_bytes,
    output setup_info_t  info
);

    logic setup_unused;

    // Field extraction: direction bit and little-endian length.
    always_comb begin
        info.to_host = setup_bytes[7];
        info.req_len = {setup_bytes[63:56], setup_bytes[55:48]};
    end

    // Request code, value and index are decoded elsewhere.
    assign setup_unused = ^{setup_bytes[47:8], setup_bytes[6:0]};

endmodule

// File: rtl/ep0_remain_count.sv
// Module: counts the bytes of the data stage still owed, and offers the
// size of the next device-to-host packet.
// Assumes: load and consume are never both high; consume never exceeds
// the remaining count (the sequencer screens oversize packets first).
module ep0_remain_count
    import ep0_ctl_pkg::*;
#(
    parameter int MPS   = 8,
    parameter int LEN_W = $clog2(MPS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REQ_W-1:0]  load_len,
    input  logic              consume,
    input  logic [LEN_W-1:0]  consume_len,
    output logic [REQ_W-1:0]  remaining,
    output logic [LEN_W-1:0]  chunk
);

    localparam logic [REQ_W-1:0] MPS_R = REQ_W'(MPS);
    localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MPS);

    // Remaining-byte register: reload on setup, reduce on each packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_len;
        else if (consume)
            remaining <= remaining - REQ_W'(consume_len);
    end

    // Next packet size: the smaller of the remainder and the packet limit.
    always_comb begin
        if (remaining < MPS_R)
            chunk = remaining[LEN_W-1:0];
        else
            chunk = MPS_L;
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> REQ_W'(consume_len) <= remaining); // R7

    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        chunk <= MPS_L); // R8

endmodule

// File: rtl/ep0_toggle_track.sv
// Module: holds the data toggle expected on the next data packet.
// Assumes: set_one wins over flip when both are requested.
module ep0_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_one,
    input  logic flip,
    output logic exp_pid
);

    // Toggle register: forced to DATA1 at stage starts, flipped per packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exp_pid <= 1'b0;
        else if (set_one)
            exp_pid <= 1'b1;
        else if (flip)
            exp_pid <= ~exp_pid;
    end

endmodule

// File: rtl/ep0_stage_fsm.sv
// Module: stage machine of the control transfer. Decides legality of each
// token event and steers the byte counter and the toggle tracker.
// Assumes: one token event per cycle at most; an IN event means the device
// packet was delivered and acknowledged.
module ep0_stage_fsm
    import ep0_ctl_pkg::*;
#(
    parameter int MPS   = 8,
    parameter int LEN_W = $clog2(MPS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  tok_e              tok_kind,
    input  setup_info_t       info,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_pid,
    input  logic [REQ_W-1:0]  remaining,
    input  logic [LEN_W-1:0]  chunk,
    input  logic              exp_pid,
    output stage_e            stage,
    output logic              done,
    output logic              cnt_load,
    output logic              cnt_consume,
    output logic [LEN_W-1:0]  cnt_len,
    output logic              pid_set,
    output logic              pid_flip
);

    localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MPS);

    stage_e st_nx;
    logic   done_nx;
    logic   rx_fits;
    logic   out_last;
    logic   in_last;
    logic   zlp_ack;

    // Packet qualifiers shared by the stage decisions.
    always_comb begin
        rx_fits  = (rx_len <= MPS_L) && (REQ_W'(rx_len) <= remaining);
        out_last = (rx_len < MPS_L) || (REQ_W'(rx_len) == remaining);
        in_last  = (chunk < MPS_L) || (REQ_W'(chunk) == remaining);
        zlp_ack  = (rx_len == '0) && rx_pid;
    end

    // Next-stage decision and steering of counter and toggle.
    always_comb begin
        st_nx       = stage;
        done_nx     = 1'b0;
        cnt_load    = 1'b0;
        cnt_consume = 1'b0;
        cnt_len     = '0;
        pid_set     = 1'b0;
        pid_flip    = 1'b0;
        if (tok_valid && tok_kind == TK_SETUP) begin
            cnt_load = 1'b1;
            pid_set  = 1'b1;
            if (info.req_len == '0)
                st_nx = ST_SIN;
            else if (info.to_host)
                st_nx = ST_DIN;
            else
                st_nx = ST_DOUT;
        end else if (tok_valid && (tok_kind == TK_OUT || tok_kind == TK_IN)) begin
            unique case (stage)
                ST_IDLE: st_nx = ST_HALT;
                ST_DOUT: begin
                    if (tok_kind == TK_IN) begin
                        st_nx = ST_HALT;
                    end else if (rx_pid != exp_pid) begin
                        st_nx = ST_DOUT;          // repeat packet, dropped
                    end else if (!rx_fits) begin
                        st_nx = ST_HALT;
                    end else begin
                        cnt_consume = 1'b1;
                        cnt_len     = rx_len;
                        if (out_last) begin
                            st_nx   = ST_SIN;
                            pid_set = 1'b1;
                        end else begin
                            pid_flip = 1'b1;
                        end
                    end
                end
                ST_DIN: begin
                    if (tok_kind == TK_IN) begin
                        cnt_consume = 1'b1;
                        cnt_len     = chunk;
                        if (in_last) begin
                            st_nx   = ST_SOUT;
                            pid_set = 1'b1;
                        end else begin
                            pid_flip = 1'b1;
                        end
                    end else if (zlp_ack) begin
                        st_nx   = ST_IDLE;
                        done_nx = 1'b1;
                    end else begin
                        st_nx = ST_HALT;
                    end
                end
                ST_SIN: begin
                    if (tok_kind == TK_IN) begin
                        st_nx   = ST_IDLE;
                        done_nx = 1'b1;
                    end else begin
                        st_nx = ST_HALT;
                    end
                end
                ST_SOUT: begin
                    if (tok_kind == TK_OUT && zlp_ack) begin
                        st_nx   = ST_IDLE;
                        done_nx = 1'b1;
                    end else begin
                        st_nx = ST_HALT;
                    end
                end
                ST_HALT: st_nx = ST_HALT;
                default: st_nx = ST_HALT;
            endcase
        end
    end

    // Stage and completion-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            stage <= st_nx;
            done  <= done_nx;
        end
    end

    AST_ZERO_LEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TK_SETUP && info.req_len == '0) |=> stage == ST_SIN); // R3

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_HALT && !(tok_valid && tok_kind == TK_SETUP)) |=> stage == ST_HALT); // R11

    AST_IDLE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_IDLE && tok_valid && (tok_kind == TK_IN || tok_kind == TK_OUT))
        |=> stage == ST_HALT); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_QUIET_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> $stable(stage)); // R12

endmodule

// File: rtl/ep0_ctl_seq.sv
// Module: top of the endpoint-zero control sequencer. Ties the setup
// decoder, byte counter, toggle tracker and stage machine together.
// Assumes: MPS is one of 8, 16, 32 or 64; all outputs are registered
// except tx_len, which is a function of registered state only.
module ep0_ctl_seq
    import ep0_ctl_pkg::*;
#(
    parameter  int MPS   = 8,
    localparam int LEN_W = $clog2(MPS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [63:0]       setup_bytes,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_pid,
    output logic [2:0]        stage,
    output logic              exp_pid,
    output logic              stall,
    output logic [LEN_W-1:0]  tx_len,
    output logic              xfer_done
);

    setup_info_t       info;
    stage_e            st;
    logic [REQ_W-1:0]  remaining;
    logic [LEN_W-1:0]  chunk;
    logic              cnt_load;
    logic              cnt_consume;
    logic [LEN_W-1:0]  cnt_len;
    logic              pid_set;
    logic              pid_flip;

    ep0_setup_decode u_dec (
        .setup_bytes (setup_bytes),
        .info        (info)
    );

    ep0_remain_count #(.MPS(MPS), .LEN_W(LEN_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cnt_load),
        .load_len    (info.req_len),
        .consume     (cnt_consume),
        .consume_len (cnt_len),
        .remaining   (remaining),
        .chunk       (chunk)
    );

    ep0_toggle_track u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_one (pid_set),
        .flip    (pid_flip),
        .exp_pid (exp_pid)
    );

    ep0_stage_fsm #(.MPS(MPS), .LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_valid   (tok_valid),
        .tok_kind    (tok_e'(tok_kind)),
        .info        (info),
        .rx_len      (rx_len),
        .rx_pid      (rx_pid),
        .remaining   (remaining),
        .chunk       (chunk),
        .exp_pid     (exp_pid),
        .stage       (st),
        .done        (xfer_done),
        .cnt_load    (cnt_load),
        .cnt_consume (cnt_consume),
        .cnt_len     (cnt_len),
        .pid_set     (pid_set),
        .pid_flip    (pid_flip)
    );

    // Output mapping: stage code, stall flag and next transmit size.
    always_comb begin
        stage  = st;
        stall  = (st == ST_HALT);
        tx_len = (st == ST_DIN) ? chunk : '0;
    end

    AST_SETUP_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'd3) |=> (!stall && exp_pid)); // R2

    AST_STATUS_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd3 || stage == 3'd4) |-> exp_pid); // R6

endmodule

// File: tb/tb_ep0_ctl_seq.sv
module tb_ep0_ctl_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MPS        = 8;
    localparam int LW         = $clog2(MPS) + 1;

    typedef struct packed {
        logic          v;
        logic [1:0]    k;
        logic [63:0]   sb;
        logic [LW-1:0] rl;
        logic          rp;
        logic [2:0]    st;
        logic          pid;
        logic          stl;
        logic [LW-1:0] tl;
        logic          dn;
        logic [3:0]    rq;
    } vec_t;

    function automatic logic [63:0] su(input logic dir, input logic [15:0] len);
        return {len[15:8], len[7:0], 40'h0, dir, 7'h00};
    endfunction

    localparam int NV = 42;
    // Columns: valid, token, setup, rx_len, rx_pid | stage, pid, stall, tx_len, done, req
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd3, su(1'b1, 16'd20), 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd8, 1'b0, 4'd4},  // R4 read of 20
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd2, 1'b0, 1'b0, 4'd8, 1'b0, 4'd8},            // R8
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd4, 1'b0, 4'd8},            // R8 tail of 4
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd0, 1'b0, 4'd8},            // R8 short ends
        '{1'b1, 2'd1, 64'h0, 4'd0, 1'b1, 3'd0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd9},            // R9
        '{1'b0, 2'd0, 64'h0, 4'd0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd0, 1'b0, 4'd9},            // R9 pulse drops
        '{1'b1, 2'd3, su(1'b0, 16'd16), 4'd0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd0, 1'b0, 4'd4}, // R4 write of 16
        '{1'b1, 2'd1, 64'h0, 4'd8, 1'b1, 3'd1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd5},            // R5
        '{1'b1, 2'd1, 64'h0, 4'd8, 1'b1, 3'd1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd5},            // R5 repeat dropped
        '{1'b1, 2'd1, 64'h0, 4'd8, 1'b0, 3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 4'd6},            // R6 length used up
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd9},            // R9
        '{1'b1, 2'd3, su(1'b0, 16'd0), 4'd0, 1'b0, 3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 4'd3},  // R3
        '{1'b1, 2'd1, 64'h0, 4'd0, 1'b1, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd11},           // R11 OUT in status-IN
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd11},           // R11 ignored while halted
        '{1'b1, 2'd3, su(1'b1, 16'd3), 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd3, 1'b0, 4'd2},  // R2 clears stall
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd0, 1'b0, 4'd8},            // R8
        '{1'b1, 2'd1, 64'h0, 4'd0, 1'b1, 3'd0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd9},            // R9
        '{1'b1, 2'd3, su(1'b0, 16'd5), 4'd0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd0, 1'b0, 4'd4},  // R4
        '{1'b1, 2'd1, 64'h0, 4'd6, 1'b1, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd7},            // R7 beyond request
        '{1'b1, 2'd3, su(1'b0, 16'd20), 4'd0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd0, 1'b0, 4'd2}, // R2
        '{1'b1, 2'd1, 64'h0, 4'd9, 1'b1, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd7},            // R7 beyond packet limit
        '{1'b1, 2'd3, su(1'b0, 16'd12), 4'd0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd0, 1'b0, 4'd2}, // R2
        '{1'b1, 2'd1, 64'h0, 4'd4, 1'b1, 3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 4'd6},            // R6 short packet
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd9},            // R9
        '{1'b1, 2'd3, su(1'b1, 16'd64), 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd8, 1'b0, 4'd4}, // R4
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd2, 1'b0, 1'b0, 4'd8, 1'b0, 4'd8},            // R8
        '{1'b1, 2'd1, 64'h0, 4'd0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd10},           // R10 early status
        '{1'b1, 2'd3, su(1'b1, 16'd40), 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd8, 1'b0, 4'd4}, // R4
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd2, 1'b0, 1'b0, 4'd8, 1'b0, 4'd8},            // R8
        '{1'b1, 2'd3, su(1'b0, 16'd2), 4'd0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd0, 1'b0, 4'd2},  // R2 mid-transfer restart
        '{1'b1, 2'd1, 64'h0, 4'd2, 1'b1, 3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 4'd6},            // R6
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd9},            // R9
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd11},           // R11 IN in idle
        '{1'b1, 2'd3, su(1'b1, 16'd8), 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd8, 1'b0, 4'd2},  // R2
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd0, 1'b0, 4'd8},            // R8 exact multiple
        '{1'b1, 2'd1, 64'h0, 4'd1, 1'b1, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd11},           // R11 data in status-OUT
        '{1'b1, 2'd0, 64'h0, 4'd0, 1'b0, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd12},           // R12 code 0
        '{1'b1, 2'd3, su(1'b1, 16'd1), 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd1, 1'b0, 4'd2},  // R2
        '{1'b1, 2'd0, 64'h0, 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd1, 1'b0, 4'd12},           // R12 code 0
        '{1'b0, 2'd2, 64'h0, 4'd0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd1, 1'b0, 4'd12},           // R12 valid low
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd0, 1'b0, 4'd8},            // R8
        '{1'b1, 2'd2, 64'h0, 4'd0, 1'b0, 3'd5, 1'b1, 1'b1, 4'd0, 1'b0, 4'd11}            // R11 IN in status-OUT
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tok_valid;
    logic [1:0]    tok_kind;
    logic [63:0]   setup_bytes;
    logic [LW-1:0] rx_len;
    logic          rx_pid;
    logic [2:0]    stage;
    logic          exp_pid;
    logic          stall;
    logic [LW-1:0] tx_len;
    logic          xfer_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ep0_ctl_seq #(.MPS(MPS)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_valid   (tok_valid),
        .tok_kind    (tok_kind),
        .setup_bytes (setup_bytes),
        .rx_len      (rx_len),
        .rx_pid      (rx_pid),
        .stage       (stage),
        .exp_pid     (exp_pid),
        .stall       (stall),
        .tx_len      (tx_len),
        .xfer_done   (xfer_done)
    );

    task automatic check_all(input string tag, input logic [2:0] e_st, input logic e_pid,
                             input logic e_stl, input logic [LW-1:0] e_tl, input logic e_dn);
        n_checks++;
        if (stage !== e_st || exp_pid !== e_pid || stall !== e_stl ||
            tx_len !== e_tl || xfer_done !== e_dn) begin
            n_fails++;
            $display("FAIL %s: stage=%0d pid=%0d stall=%0d tx_len=%0d done=%0d, expected %0d %0d %0d %0d %0d",
                     tag, stage, exp_pid, stall, tx_len, xfer_done,
                     e_st, e_pid, e_stl, e_tl, e_dn);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [63:0] sb,
                         input logic [LW-1:0] rl, input logic rp);
        tok_valid   = v;
        tok_kind    = k;
        setup_bytes = sb;
        rx_len      = rl;
        rx_pid      = rp;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 2'd0, 64'h0, '0, 1'b0);
        repeat (3) @(negedge clk);
        check_all("R1 reset state", 3'd0, 1'b0, 1'b0, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release", 3'd0, 1'b0, 1'b0, '0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].k, TBL[i].sb, TBL[i].rl, TBL[i].rp);
            @(negedge clk);
            check_all($sformatf("R%0d vector %0d", TBL[i].rq, i),
                      TBL[i].st, TBL[i].pid, TBL[i].stl, TBL[i].tl, TBL[i].dn);
        end

        // Directed: reset in the middle of a read clears everything (R1).
        drive(1'b1, 2'd3, su(1'b1, 16'd30), '0, 1'b0);
        @(negedge clk);
        drive(1'b1, 2'd2, 64'h0, '0, 1'b0);
        @(negedge clk);
        drive(1'b0, 2'd0, 64'h0, '0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 mid-transfer reset", 3'd0, 1'b0, 1'b0, '0, 1'b0);
        rst_n = 1'b1;

        // Directed: repeated SETUP with a wide packet count rolls the toggle back (R2).
        drive(1'b1, 2'd3, su(1'b0, 16'd24), '0, 1'b0);
        @(negedge clk);
        drive(1'b1, 2'd1, 64'h0, 4'd8, 1'b1);
        @(negedge clk);
        check_all("R5 first write packet", 3'd1, 1'b0, 1'b0, '0, 1'b0);
        drive(1'b1, 2'd3, su(1'b0, 16'd24), '0, 1'b0);
        @(negedge clk);
        check_all("R2 toggle restored", 3'd1, 1'b1, 1'b0, '0, 1'b0);
        drive(1'b0, 2'd0, 64'h0, '0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule